// File: doc/BRIEF.md
# Depth-12 Convolutional Byte Deinterleaver

This block undoes the convolutional interleaving applied to a byte stream before transmission. Each valid byte goes to the next of twelve branches in turn. Each branch is a delay line whose length gets shorter as the branch index rises. The delay a byte gets here, added to the delay it got in the matching interleaver, is the same for every byte. The original order comes back once the link has filled.

The block sits in a receive path between the demodulator and the block decoder. Its input is a byte with a valid strobe and an enable. Its output is the same byte, or the byte this branch stored earlier, together with a valid flag.

Branch alignment has one source only: the block assumes that the first enabled valid byte after reset is a sync byte and sends it to the longest branch. Invalid bytes go through with no delay and do not move the branch selector. When the block is disabled, every byte goes through with no delay and the stored state is frozen. All branch storage is one internal RAM. Each branch uses its own region of the RAM as a circular buffer with its own pointer.

Top module: `conv_deinterleaver`

## Requirements
- R1: Branches are numbered 0 to 11. After reset, the first byte with `en`=1 and `in_valid`=1 goes to branch 0. Each later such byte goes to the next branch, with a wrap from 11 to 0. No other input cycle changes the branch selector.
- R2: Branch j holds (11 - j) x 17 bytes. A byte written to branch j comes out on the visit to branch j that is (11 - j) x 17 visits later. That equals 12 x 17 x (11 - j) enabled valid bytes later, so branch 0 delays by 2244.
- R3: The outputs are registered. Each output cycle refers to the input one clock earlier. During reset and right after it, `out_valid` is 0 and `out_byte` is 0.
- R4: A byte routed to branch 11 has zero delay: `out_byte` on the next clock is that same byte.
- R5: When `in_valid`=0, the next clock shows `out_valid`=0 and `out_byte` equal to the input byte. The branch selector and the stored bytes do not change.
- R6: When `en`=0, the next clock shows `out_valid` equal to `in_valid` and `out_byte` equal to the input byte. The branch selector and the stored bytes do not change.
- R7: Until branch j has been visited (11 - j) x 17 times since reset, a visit to branch j outputs the byte value 0x00.
- R8: The block is fed by a matching interleaver, in which branch j delays by j x 17 visits and the first byte goes to branch 0. Enabled valid output number k (counted from 0) then equals original byte number k - 2244, for every k of 2244 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | 1 = deinterleave; 0 = pass every byte through with no delay |
| in_valid | input | 1 | The input byte is a data byte |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_byte | output | 8 | Byte delayed by the current branch, or the registered input byte on a bypass |

## Verification
A wrong branch selector shows up at once. A byte meant for branch 11 comes out changed on the next clock. Every later comparison against the per-branch queue model also fails, so even a one-step slip is caught within twelve valid bytes. A pointer or fill flag that is wrong inside one branch shows up on the first read that returns a wrong byte, or a nonzero byte before the fill is complete. The end-to-end comparison against the original stream catches any mismatch in delay length once 2244 valid bytes have passed.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

  // Number of bytes held by branch j
  function automatic int branch_len(input int j, input int depth, input int unit);
    return (depth - 1 - j) * unit;
  endfunction

  // First RAM word of branch j: sum of the lengths of the branches before it
  function automatic int branch_base(input int j, input int depth, input int unit);
    int acc;
    acc = 0;
    for (int k = 0; k < j; k++) acc += branch_len(k, depth, unit);
    return acc;
  endfunction

  // Total RAM words needed by all branches
  function automatic int store_words(input int depth, input int unit);
    return unit * depth * (depth - 1) / 2;
  endfunction

endpackage

// File: rtl/cdi_commutator.sv
module cdi_commutator #(
  parameter int DEPTH = 12,
  parameter int SW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [SW-1:0] sel,
  output logic          wrap
);
  assign wrap = step && (sel == SW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    sel <= '0;
    else if (wrap) sel <= '0;
    else if (step) sel <= sel + SW'(1);
  end
endmodule

// File: rtl/cdi_branch_ptr.sv
module cdi_branch_ptr #(
  parameter int LEN = 17,
  parameter int AW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  output logic [AW-1:0] ptr,
  output logic          filled
);
  generate
    if (LEN == 0) begin : g_nostore
      assign ptr    = '0;
      assign filled = 1'b1;
    end else begin : g_ring
      logic at_end;
      assign at_end = (ptr == AW'(LEN - 1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ptr    <= '0;
          filled <= 1'b0;
        end else if (hit) begin
          ptr <= at_end ? '0 : ptr + AW'(1);
          if (at_end) filled <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cdi_store.sv
module cdi_store #(
  parameter int W     = 8,
  parameter int WORDS = 1122,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  // read-before-write: the old word leaves as the new word enters
  always_ff @(posedge clk) begin
    if (we) begin
      rdata     <= mem[addr];
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver
  import cdi_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int UNIT  = 17,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] in_byte,
  output logic         out_valid,
  output logic [W-1:0] out_byte
);
  localparam int WORDS = store_words(DEPTH, UNIT);
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // named internal events
  logic             step_w;
  logic [SW-1:0]    br_sel;
  logic             br_wrap;
  logic [DEPTH-1:0] filled_v;
  logic [DEPTH-1:0] has_store;
  logic [AW-1:0]    br_addr [DEPTH];
  logic [AW-1:0]    ram_addr;
  logic             ram_we;
  logic [W-1:0]     ram_rd;

  assign step_w = en && in_valid;

  cdi_commutator #(.DEPTH(DEPTH), .SW(SW)) u_comm (
    .clk(clk), .rst_n(rst_n), .step(step_w), .sel(br_sel), .wrap(br_wrap)
  );

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_br
      localparam int LEN  = branch_len(g, DEPTH, UNIT);
      localparam int BASE = branch_base(g, DEPTH, UNIT);
      logic [AW-1:0] ptr_g;
      cdi_branch_ptr #(.LEN(LEN), .AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .hit(step_w && (br_sel == SW'(g))),
        .ptr(ptr_g), .filled(filled_v[g])
      );
      assign br_addr[g]   = AW'(BASE) + ptr_g;
      assign has_store[g] = (LEN != 0);
    end
  endgenerate

  assign ram_addr = br_addr[br_sel];
  assign ram_we   = step_w && has_store[br_sel];

  cdi_store #(.W(W), .WORDS(WORDS), .AW(AW)) u_store (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(in_byte), .rdata(ram_rd)
  );

  // output stage
  logic         s_pass;
  logic         s_filled;
  logic [W-1:0] s_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      s_pass    <= 1'b1;
      s_filled  <= 1'b0;
      s_byte    <= '0;
    end else begin
      out_valid <= in_valid;
      s_pass    <= !ram_we;
      s_filled  <= filled_v[br_sel];
      s_byte    <= in_byte;
    end
  end

  assign out_byte = s_pass ? s_byte : (s_filled ? ram_rd : '0);
endmodule

// File: rtl/cdi_checker.sv
module cdi_checker #(
  parameter int DEPTH = 12,
  parameter int SW    = 4,
  parameter int W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             in_valid,
  input logic [W-1:0]     in_byte,
  input logic             out_valid,
  input logic [W-1:0]     out_byte,
  input logic             step_w,
  input logic [SW-1:0]    br_sel,
  input logic [DEPTH-1:0] filled_v
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid)); // R3
  AST_SEL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && br_sel != SW'(DEPTH - 1)) |=> br_sel == $past(br_sel) + SW'(1)); // R1
  AST_SEL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && br_sel == SW'(DEPTH - 1)) |=> br_sel == '0); // R1
  AST_SEL_HOLD_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(br_sel)); // R5
  AST_SEL_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(br_sel)); // R6
  AST_LAST_BRANCH_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && br_sel == SW'(DEPTH - 1)) |=> out_byte == $past(in_byte)); // R4
  AST_BYPASS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> out_byte == $past(in_byte)); // R5
  AST_BYPASS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> out_byte == $past(in_byte)); // R6
  AST_UNFILLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && br_sel != SW'(DEPTH - 1) && !filled_v[br_sel]) |=> out_byte == '0); // R7
  AST_FILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (filled_v & $past(filled_v)) == $past(filled_v)); // R7
endmodule

bind conv_deinterleaver cdi_checker #(.DEPTH(DEPTH), .SW(SW), .W(W)) u_cdi_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_byte(in_byte),
  .out_valid(out_valid), .out_byte(out_byte),
  .step_w(step_w), .br_sel(br_sel), .filled_v(filled_v)
);

// File: tb/conv_deinterleaver_bench.sv
module conv_deinterleaver_bench;
  localparam int NB  = 12;
  localparam int M   = 17;
  localparam int E2E = NB * M * (NB - 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;

  always #4 clk = ~clk;

  conv_deinterleaver u_conv_deinterleaver (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int dq [NB][$];   // deinterleaver model queues
  int iq [NB][$];   // reference interleaver queues
  int visits [NB];
  int orig [$];
  int dsel = 0, isel = 0, outcnt = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one input cycle; starts and ends at a falling edge
  task automatic cycle(input bit en_i, input bit v_i, input int raw);
    int ib, e, j;
    string tag;
    bit step;
    step = en_i && v_i;
    if (step) begin
      iq[isel].push_back(raw);
      ib = iq[isel].pop_front();
      isel = (isel + 1) % NB;
      orig.push_back(raw);
    end else ib = raw;
    if (step) begin
      j = dsel;
      if (j == NB - 1) begin
        e = ib; tag = "R4";
      end else begin
        dq[j].push_back(ib);
        e = dq[j].pop_front();
        tag = (visits[j] < (NB - 1 - j) * M) ? "R7" : "R1/R2";
      end
      visits[j]++;
      dsel = (dsel + 1) % NB;
    end else begin
      e = ib;
      tag = !en_i ? "R6" : "R5";
    end
    en = en_i; in_valid = v_i; in_byte = 8'(ib);
    @(negedge clk);
    chk(tag, int'(out_valid), int'(v_i));
    chk(tag, int'(out_byte), e);
    if (step) begin
      if (outcnt >= E2E) chk("R8", int'(out_byte), orig[outcnt - E2E]);
      outcnt++;
    end
  endtask

  initial begin
    for (int j = 0; j < NB; j++) begin
      for (int k = 0; k < (NB - 1 - j) * M; k++) dq[j].push_back(0);
      for (int k = 0; k < j * M; k++) iq[j].push_back(0);
      visits[j] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R3", int'(out_valid), 0);
    chk("R3", int'(out_byte), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", int'(out_valid), 0);
    // invalid bytes before the first valid one must not move the selector
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 8'hA0 + i);
    // disabled bytes, valid and invalid, before alignment
    for (int i = 0; i < 4; i++) cycle(1'b0, i[0], 8'h50 + i);
    for (int i = 0; i < 4200; i++) begin
      bit dis, v;
      dis = (i >= 1500 && i < 1560);
      v = ((i % 7) != 3) && ((i % 53) != 10);
      cycle(!dis, v, int'($urandom_range(255)));
    end
    chk("R8", int'(outcnt > E2E + 500), 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule